// File: doc/BRIEF.md
# Shutdown / Output-Enable Pin Decoder

This block turns one external control pin into a drive state for each of several clock outputs. Register bits choose what the pin means. A polarity bit sets whether the pin asserts when high or when low. A mode bit makes the pin either a global shutdown of the synthesizer or an output-enable control. Each output also has a local enable bit and a bit that places the output under control of the pin. The block sends its results to the pad drivers and to the synthesizer's power control. The pad drivers and the PLL are outside this block.

The pin is asynchronous, so it first passes through a two-flop synchronizer. The block then decodes it together with the configuration bits. A register stage holds each output's two-bit state and the shutdown request. When an output is disabled it is parked at a defined level. It is tri-stated only when its local enable is cleared.

Top module: `oepin_ctrl`

## Requirements
- R1: While rst_n is low, every drive state is tri-state (00) and shutdown_req is 0.
- R2: Each output's drive state is two bits of drv_state (output k at bits 2k+1:2k), coded 00 tri-state, 01 active, 10 parked. The code 11 never appears.
- R3: With pol_hi = 0 the pin counts as asserted when it is low. With pol_hi = 1 it counts as asserted when it is high.
- R4: An output whose loc_en bit is 0 is tri-state, whatever its pin_gov bit and the pin level. The only exception is an asserted global shutdown.
- R5: In enable mode (shut_mode = 0), an output with loc_en = 1 and pin_gov = 0 is active at either pin level.
- R6: In enable mode, an output with loc_en = 1 and pin_gov = 1 is active while the pin is asserted and parked while it is deasserted.
- R7: In shutdown mode (shut_mode = 1) with the pin asserted, shutdown_req is 1 and every output is parked.
- R8: In shutdown mode with the pin deasserted, shutdown_req is 0 and pin_gov has no effect: each output is active when loc_en = 1 and tri-state when loc_en = 0.
- R9: A change on ctl_pin reaches the outputs at the third rising clock edge after it. A change on a configuration input reaches them at the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | External shutdown / enable pin, asynchronous |
| pol_hi | input | 1 | 1: pin asserts high; 0: pin asserts low |
| shut_mode | input | 1 | 1: pin is global shutdown; 0: pin is output enable |
| pin_gov | input | NUM_OUT | Per output: the pin governs this output |
| loc_en | input | NUM_OUT | Per output: local enable |
| drv_state | output | 2*NUM_OUT | Per-output drive state code |
| shutdown_req | output | 1 | Registered global shutdown request |

## Verification
The assertions assume that the configuration inputs are synchronous to clk and stay steady between edges. They also observe the pin only after it has been synchronized, so each property links the synchronized pin level and the configuration to the registered state one edge later. The bench meets these assumptions. It changes every input shortly after a falling edge, holds the new values for several cycles, and compares only after the synchronizer and the output register have settled. The one exception is the latency test, which samples deliberately between edges.

// File: rtl/oepin_pkg.sv
package oepin_pkg;

  typedef enum logic [1:0] {
    DRV_TRI  = 2'b00,
    DRV_ACT  = 2'b01,
    DRV_PARK = 2'b10
  } drv_t;

  // Next drive state of one output from the decoded pin and its config bits.
  function automatic drv_t lane_next(input logic shut_mode, input logic pin_on,
                                     input logic gov, input logic en);
    drv_t r;
    if (shut_mode && pin_on)      r = DRV_PARK;
    else if (!en)                 r = DRV_TRI;
    else if (shut_mode || !gov)   r = DRV_ACT;
    else if (pin_on)              r = DRV_ACT;
    else                          r = DRV_PARK;
    return r;
  endfunction

  // Pin level to asserted flag under the polarity setting.
  function automatic logic pin_asserted(input logic lvl, input logic pol_hi);
    return pol_hi ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/oepin_sync.sv
module oepin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/oepin_lane.sv
module oepin_lane
  import oepin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_on,
  input  logic shut_mode,
  input  logic gov,
  input  logic en,
  output drv_t state
);
  drv_t nxt;

  always_comb nxt = lane_next(shut_mode, pin_on, gov, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= DRV_TRI;
    else        state <= nxt;
  end
endmodule

// File: rtl/oepin_ctrl.sv
module oepin_ctrl
  import oepin_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_pin,
  input  logic                 pol_hi,
  input  logic                 shut_mode,
  input  logic [NUM_OUT-1:0]   pin_gov,
  input  logic [NUM_OUT-1:0]   loc_en,
  output logic [2*NUM_OUT-1:0] drv_state,
  output logic                 shutdown_req
);
  localparam int STW = 2 * NUM_OUT;

  // Named internal events, observed by the checker.
  logic pin_sync;
  logic pin_on;
  logic shut_now;

  oepin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(ctl_pin),
    .q_sync (pin_sync)
  );

  assign pin_on   = pin_asserted(pin_sync, pol_hi);
  assign shut_now = shut_mode & pin_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shutdown_req <= 1'b0;
    else        shutdown_req <= shut_now;
  end

  logic [STW-1:0] st_bus;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    drv_t st;
    oepin_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_on   (pin_on),
      .shut_mode(shut_mode),
      .gov      (pin_gov[k]),
      .en       (loc_en[k]),
      .state    (st)
    );
    assign st_bus[2*k +: 2] = st;
  end

  assign drv_state = st_bus;
endmodule

// File: rtl/oepin_ctrl_chk.sv
module oepin_ctrl_chk #(
  parameter int NUM_OUT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pin_on,
  input logic                 shut_mode,
  input logic [NUM_OUT-1:0]   pin_gov,
  input logic [NUM_OUT-1:0]   loc_en,
  input logic [2*NUM_OUT-1:0] drv_state,
  input logic                 shutdown_req
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (drv_state == '0 && !shutdown_req));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_state[2*k +: 2] != 2'b11);
    // R4
    local_off_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!loc_en[k] && !(shut_mode && pin_on)) |=> drv_state[2*k +: 2] == 2'b00);
    // R6
    oe_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shut_mode && loc_en[k] && pin_gov[k] && !pin_on) |=> drv_state[2*k +: 2] == 2'b10);
    // R7
    shutdown_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> drv_state[2*k +: 2] == 2'b10);
  end

  // R8
  sd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_mode && !pin_on) |=> !shutdown_req);
endmodule

bind oepin_ctrl oepin_ctrl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_on      (pin_on),
  .shut_mode   (shut_mode),
  .pin_gov     (pin_gov),
  .loc_en      (loc_en),
  .drv_state   (drv_state),
  .shutdown_req(shutdown_req)
);

// File: tb/sim_oepin_ctrl.sv
module sim_oepin_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_pin = 1'b1, pol_hi = 1'b0, shut_mode = 1'b0;
  logic [N-1:0] pin_gov = '0, loc_en = '0;
  logic [2*N-1:0] drv_state;
  logic shutdown_req;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  oepin_ctrl #(.NUM_OUT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .pol_hi(pol_hi),
    .shut_mode(shut_mode), .pin_gov(pin_gov), .loc_en(loc_en),
    .drv_state(drv_state), .shutdown_req(shutdown_req)
  );

  typedef struct {
    logic [2*N-1:0] st;
    logic           sd;
    string          tag;
  } item_t;

  item_t sb[$];

  // Independent model, written as a table over the pin meaning.
  function automatic logic [1:0] model(logic sh, logic pin, logic pol, logic g, logic e);
    logic on;
    on = (pin == pol);
    case ({sh, on})
      2'b11:   return 2'b10;
      2'b10:   return e ? 2'b01 : 2'b00;
      2'b01:   return e ? 2'b01 : 2'b00;
      default: return !e ? 2'b00 : (g ? 2'b10 : 2'b01);
    endcase
  endfunction

  task automatic check(string tag, logic [2*N-1:0] got, logic [2*N-1:0] exp,
                       logic gsd, logic esd);
    n_run++;
    if (got !== exp || gsd !== esd) begin
      n_fail++;
      $display("FAIL %s: drv=%b sd=%b expected drv=%b sd=%b", tag, got, gsd, exp, esd);
    end
  endtask

  task automatic apply(string tag, logic pin, logic pol, logic sh,
                       logic [N-1:0] g, logic [N-1:0] e);
    item_t it;
    ctl_pin = pin; pol_hi = pol; shut_mode = sh; pin_gov = g; loc_en = e;
    for (int k = 0; k < N; k++) it.st[2*k +: 2] = model(sh, pin, pol, g[k], e[k]);
    it.sd  = sh && (pin == pol);
    it.tag = tag;
    repeat (4) @(negedge clk);
    sb.push_back(it);
    @(negedge clk);
    #5;
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, drv_state, it.st, shutdown_req, it.sd);
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check("R1 reset", drv_state, '0, shutdown_req, 1'b0);
    #5 rst_n = 1'b1;
    @(negedge clk); #5;

    // R5 ungoverned outputs active at both pin levels
    apply("R5 pin high", 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1111);
    apply("R5 pin low",  1'b0, 1'b0, 1'b0, 4'b0000, 4'b1111);
    // R3 active-low: pin low asserts (enable), high deasserts (park)
    apply("R3 R6 low pol asserted",   1'b0, 1'b0, 1'b0, 4'b1111, 4'b1111);
    apply("R3 R6 low pol deasserted", 1'b1, 1'b0, 1'b0, 4'b1111, 4'b1111);
    // R3 active-high
    apply("R3 R6 high pol asserted",   1'b1, 1'b1, 1'b0, 4'b1111, 4'b1111);
    apply("R3 R6 high pol deasserted", 1'b0, 1'b1, 1'b0, 4'b1111, 4'b1111);
    // R4 local enable off overrides pin control
    apply("R4 mixed OE mode", 1'b1, 1'b0, 1'b0, 4'b1010, 4'b0110);
    apply("R4 all off",       1'b0, 1'b0, 1'b0, 4'b1111, 4'b0000);
    // R2 all three codes present at once
    apply("R2 code mix", 1'b1, 1'b0, 1'b0, 4'b0110, 4'b1110);
    // R7 shutdown asserted parks all, even locally disabled
    apply("R7 shutdown low pol",  1'b0, 1'b0, 1'b1, 4'b0101, 4'b0011);
    apply("R7 shutdown high pol", 1'b1, 1'b1, 1'b1, 4'b0000, 4'b0000);
    // R8 shutdown mode deasserted: gov ignored
    apply("R8 sd idle gov set",   1'b1, 1'b0, 1'b1, 4'b1111, 4'b1011);
    apply("R8 sd idle gov clear", 1'b0, 1'b1, 1'b1, 4'b0000, 4'b1011);

    // R9 latency: pin asserts shutdown; unchanged after two edges, set after third
    apply("R9 setup", 1'b1, 1'b0, 1'b1, 4'b0000, 4'b1111);
    ctl_pin = 1'b0;                      // 5 ns after negedge
    @(negedge clk); @(negedge clk); #2;  // two rising edges passed
    check("R9 after two edges", drv_state, 8'b01010101, shutdown_req, 1'b0);
    @(negedge clk); #2;                  // third rising edge passed
    check("R9 after third edge", drv_state, 8'b10101010, shutdown_req, 1'b1);
    #3;
    // R9 config change visible after one edge
    shut_mode = 1'b0; pin_gov = 4'b0000;
    @(negedge clk); #2;
    check("R9 config one edge", drv_state, 8'b01010101, shutdown_req, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule